// File: doc/BRIEF.md
# Integer-N Synthesiser Divider and Phase Comparator

This block is the digital heart of an integer-N frequency synthesiser loop. It divides a prescaled oscillator clock by a 15-bit programmable ratio and a reference clock by either 512 or 1024. It compares the two divided signals in a three-state phase/frequency detector, which drives charge-pump pump-up and pump-down requests. A lock monitor watches how wide those requests are and raises a lock flag once the loop has settled. The oscillator is prescaled by eight outside the block, so the synthesised frequency is the ratio times eight times the comparison frequency. For example, a 4 MHz reference divided by 512 gives a 7.8125 kHz comparison frequency.

Everything runs on one system clock. The prescaled oscillator and the reference arrive as one-cycle tick strobes that are already synchronised to that clock. Each divider ends its period with a one-cycle terminal pulse. The oscillator-side pulse, a half-rate toggle of it and the comparison pulse are brought out so that test logic can route them to pins. The ratio comes in as the two fields that the register file holds: a 7-bit upper part and an 8-bit lower part.

Top module: `synth_pll_core`

## Requirements
- R1: While reset is high and on the first sample after reset, up_o, dn_o, lock_o, fpd_o, fpd_half_o and fcomp_o are all 0.
- R2: The ratio is N = {ratio_hi_i, ratio_lo_i}, with ratio_hi_i in bits 14..8. The first rf tick after reset produces an fpd_o pulse one cycle wide in the next cycle. After that, fpd_o pulses once every N rf ticks. A ratio of 0 acts as 1.
- R3: A new ratio is sampled only on the rf tick that ends a divider period, so the period in progress always completes with the old ratio.
- R4: fcomp_o pulses once every 512 ref ticks when ref_sel_i is 1 and once every 1024 ref ticks when it is 0. The first ref tick after reset produces a pulse. A change of ref_sel_i takes effect only at the end of the current period.
- R5: fpd_half_o toggles in the cycle that follows each fpd_o pulse, so it runs at half the rate of fpd_o.
- R6: When fcomp_o leads fpd_o by d cycles, up_o alone is high for d cycles. Then up_o and dn_o are both high for one cycle, and then both drop.
- R7: When fpd_o leads fcomp_o by d cycles, dn_o alone is high for d cycles. Then both are high for one cycle, and then both drop. Pulses in the same cycle give no single-sided cycle at all.
- R8: lock_o rises after 8 consecutive comparisons whose single-sided width d is at most 4 cycles.
- R9: A comparison with d greater than 4 clears lock_o at once and restarts the count of good comparisons.
- R10: up_o and dn_o are never both high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rf_tick_i | input | 1 | One-cycle strobe per prescaled oscillator cycle |
| ref_tick_i | input | 1 | One-cycle strobe per reference cycle |
| ratio_hi_i | input | 7 | Ratio bits 14..8 |
| ratio_lo_i | input | 8 | Ratio bits 7..0 |
| ref_sel_i | input | 1 | 1: reference divide by 512, 0: divide by 1024 |
| up_o | output | 1 | Charge-pump pump-up request |
| dn_o | output | 1 | Charge-pump pump-down request |
| lock_o | output | 1 | Loop locked flag |
| fpd_o | output | 1 | Programmable divider terminal pulse |
| fpd_half_o | output | 1 | fpd_o divided by two |
| fcomp_o | output | 1 | Comparison-frequency pulse |

## Verification
The hardest condition to reach is a detector phase offset that is exact and repeatable across many comparison periods, with the oscillator leading as well as lagging. Only that lets the lock threshold be probed at its edge. The bench sets the ratio to 1, so every rf tick is a terminal count. It holds the reference tick high continuously, so each comparison period is exactly 512 cycles. Then it places single rf ticks at chosen offsets inside each period. Offsets of 4 and 5 land on either side of the threshold, and interleaving them shows that one bad period restarts the count of good ones.

// File: rtl/synth_pkg.sv
package synth_pkg;

    // Outcome of one completed phase comparison
    typedef enum logic [1:0] {
        CMP_IDLE = 2'd0,
        CMP_GOOD = 2'd1,
        CMP_BAD  = 2'd2
    } cmp_kind_e;

    // Charge-pump request pair
    typedef struct packed {
        logic up;
        logic dn;
    } pump_req_t;

    function automatic logic pump_both(input pump_req_t r);
        return r.up & r.dn;
    endfunction

    function automatic logic pump_single(input pump_req_t r);
        return r.up ^ r.dn;
    endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] load,
    output logic          term
);
    logic [CW-1:0] cnt;

    // cnt <= 1 marks the last tick of a period; reload samples load only there
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            term <= 1'b0;
        end else begin
            term <= 1'b0;
            if (tick) begin
                if (cnt <= CW'(1)) begin
                    cnt  <= load;
                    term <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R2
    term_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        term |-> $past(tick));

    // R3
    no_early_term_chk: assert property (@(posedge clk) disable iff (rst)
        (term && $past(load) > CW'(1)) |=> !term);

endmodule

// File: rtl/phase_detector.sv
module phase_detector
    import synth_pkg::*;
#(
    parameter int LOCK_THRESH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fcomp_p,
    input  logic      fpd_p,
    output pump_req_t req,
    output cmp_kind_e cmp
);
    localparam int WW = $clog2(LOCK_THRESH + 2);
    localparam logic [WW-1:0] WMAX = WW'(LOCK_THRESH + 1);
    localparam logic [WW-1:0] WLIM = WW'(LOCK_THRESH);

    logic [WW-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            req  <= '0;
            wcnt <= '0;
        end else if (pump_both(req)) begin
            req  <= '0;
            wcnt <= '0;
        end else begin
            if (fcomp_p) req.up <= 1'b1;
            if (fpd_p)   req.dn <= 1'b1;
            if (pump_single(req) && wcnt != WMAX) wcnt <= wcnt + WW'(1);
        end
    end

    always_comb begin
        if (!pump_both(req))   cmp = CMP_IDLE;
        else if (wcnt <= WLIM) cmp = CMP_GOOD;
        else                   cmp = CMP_BAD;
    end

    // R10
    both_once_chk: assert property (@(posedge clk) disable iff (rst)
        pump_both(req) |=> !pump_both(req));

    // R6
    up_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req.up) |-> $past(fcomp_p));

    // R7
    dn_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req.dn) |-> $past(fpd_p));

endmodule

// File: rtl/lock_detector.sv
module lock_detector
    import synth_pkg::*;
#(
    parameter int LOCK_COUNT = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  cmp_kind_e cmp,
    output logic      lock
);
    localparam int GW = $clog2(LOCK_COUNT + 1);
    localparam logic [GW-1:0] GLAST = GW'(LOCK_COUNT - 1);

    logic [GW-1:0] good_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            good_cnt <= '0;
            lock     <= 1'b0;
        end else begin
            case (cmp)
                CMP_GOOD: begin
                    if (good_cnt == GLAST) lock <= 1'b1;
                    else                   good_cnt <= good_cnt + GW'(1);
                end
                CMP_BAD: begin
                    good_cnt <= '0;
                    lock     <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R8
    lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(cmp == CMP_GOOD));

    // R9
    bad_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (cmp == CMP_BAD) |=> !lock);

endmodule

// File: rtl/synth_pll_core.sv
module synth_pll_core
    import synth_pkg::*;
#(
    parameter int RATIO_W     = 15,
    parameter int LO_W        = 8,
    parameter int REF_LOG2    = 9,
    parameter int LOCK_THRESH = 4,
    parameter int LOCK_COUNT  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rf_tick_i,
    input  logic                    ref_tick_i,
    input  logic [RATIO_W-LO_W-1:0] ratio_hi_i,
    input  logic [LO_W-1:0]         ratio_lo_i,
    input  logic                    ref_sel_i,
    output logic                    up_o,
    output logic                    dn_o,
    output logic                    lock_o,
    output logic                    fpd_o,
    output logic                    fpd_half_o,
    output logic                    fcomp_o
);
    localparam int REF_CW = REF_LOG2 + 2;
    localparam logic [REF_CW-1:0] REF_SHORT = REF_CW'(1) << REF_LOG2;
    localparam logic [REF_CW-1:0] REF_LONG  = REF_CW'(1) << (REF_LOG2 + 1);

    logic [RATIO_W-1:0] ratio;
    logic [REF_CW-1:0]  ref_load;
    logic               fpd_p;
    logic               fcomp_p;
    logic               half_q;
    pump_req_t          req;
    cmp_kind_e          cmp;

    assign ratio    = {ratio_hi_i, ratio_lo_i};
    assign ref_load = ref_sel_i ? REF_SHORT : REF_LONG;

    tick_divider #(.CW(RATIO_W)) u_prog_div (
        .clk (clk),
        .rst (rst),
        .tick(rf_tick_i),
        .load(ratio),
        .term(fpd_p)
    );

    tick_divider #(.CW(REF_CW)) u_ref_div (
        .clk (clk),
        .rst (rst),
        .tick(ref_tick_i),
        .load(ref_load),
        .term(fcomp_p)
    );

    always_ff @(posedge clk) begin
        if (rst)        half_q <= 1'b0;
        else if (fpd_p) half_q <= ~half_q;
    end

    phase_detector #(.LOCK_THRESH(LOCK_THRESH)) u_pfd (
        .clk    (clk),
        .rst    (rst),
        .fcomp_p(fcomp_p),
        .fpd_p  (fpd_p),
        .req    (req),
        .cmp    (cmp)
    );

    lock_detector #(.LOCK_COUNT(LOCK_COUNT)) u_lock (
        .clk (clk),
        .rst (rst),
        .cmp (cmp),
        .lock(lock_o)
    );

    assign up_o       = req.up;
    assign dn_o       = req.dn;
    assign fpd_o      = fpd_p;
    assign fcomp_o    = fcomp_p;
    assign fpd_half_o = half_q;

    // R5
    half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (half_q != $past(half_q)) |-> $past(fpd_p));

endmodule

// File: tb/synth_pll_core_tb.sv
module synth_pll_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rf_tick = 1'b0;
    logic       ref_tick = 1'b0;
    logic [6:0] ratio_hi = '0;
    logic [7:0] ratio_lo = 8'd1;
    logic       ref_sel = 1'b1;
    logic       up_o, dn_o, lock_o, fpd_o, fpd_half_o, fcomp_o;

    int n_checks = 0;
    int n_fail   = 0;
    int up_only, dn_only, both_cnt, both_twice;
    logic prev_both;

    always #10 clk = ~clk;

    synth_pll_core u_dut (
        .clk(clk), .rst(rst), .rf_tick_i(rf_tick), .ref_tick_i(ref_tick),
        .ratio_hi_i(ratio_hi), .ratio_lo_i(ratio_lo), .ref_sel_i(ref_sel),
        .up_o(up_o), .dn_o(dn_o), .lock_o(lock_o), .fpd_o(fpd_o),
        .fpd_half_o(fpd_half_o), .fcomp_o(fcomp_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; rf_tick = 1'b0; ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_pulse(input bit use_fcomp, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(use_fcomp ? fcomp_o : fpd_o) && n < 5000);
    endtask

    task automatic clear_counts();
        up_only = 0; dn_only = 0; both_cnt = 0; both_twice = 0; prev_both = 1'b0;
    endtask

    // One 512-cycle comparison window; ref ticks every cycle, rf ticks at pa/pb
    task automatic run_window(input int pa, input int pb);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            if (up_o && !dn_o) up_only++;
            if (dn_o && !up_o) dn_only++;
            if (up_o && dn_o) begin
                both_cnt++;
                if (prev_both) both_twice++;
            end
            prev_both = up_o && dn_o;
            ref_tick = 1'b1;
            rf_tick  = (i == pa) || (i == pb);
        end
    endtask

    task automatic test_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 up",    int'(up_o),       0);
        check("R1 dn",    int'(dn_o),       0);
        check("R1 lock",  int'(lock_o),     0);
        check("R1 fpd",   int'(fpd_o),      0);
        check("R1 half",  int'(fpd_half_o), 0);
        check("R1 fcomp", int'(fcomp_o),    0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset fcomp", int'(fcomp_o), 0);
    endtask

    task automatic test_prog_div();
        int n;
        do_reset();
        ratio_hi = 7'd0; ratio_lo = 8'd5; rf_tick = 1'b1;
        wait_pulse(1'b0, n); check("R2 first pulse", n, 1);
        wait_pulse(1'b0, n); check("R2 period 5", n, 5);
        check("R5 half after one pulse", int'(fpd_half_o), 1);
        wait_pulse(1'b0, n); check("R2 period 5 again", n, 5);
        check("R5 half after two pulses", int'(fpd_half_o), 0);
        ratio_lo = 8'd3;
        wait_pulse(1'b0, n); check("R3 old ratio kept", n, 5);
        wait_pulse(1'b0, n); check("R3 new ratio 3", n, 3);
        ratio_hi = 7'd1; ratio_lo = 8'd1;
        wait_pulse(1'b0, n); check("R3 old ratio 3 kept", n, 3);
        wait_pulse(1'b0, n); check("R2 upper field ratio 257", n, 257);
        rf_tick = 1'b0;
    endtask

    task automatic test_ref_div();
        int n;
        do_reset();
        ref_sel = 1'b1; ref_tick = 1'b1;
        wait_pulse(1'b1, n); check("R4 first pulse", n, 1);
        wait_pulse(1'b1, n); check("R4 divide 512", n, 512);
        ref_sel = 1'b0;
        wait_pulse(1'b1, n); check("R4 select held until period end", n, 512);
        wait_pulse(1'b1, n); check("R4 divide 1024", n, 1024);
        ref_tick = 1'b0; ref_sel = 1'b1;
    endtask

    task automatic test_lag();
        do_reset();
        ratio_hi = 7'd0; ratio_lo = 8'd1; ref_sel = 1'b1;
        clear_counts();
        run_window(10, -1);
        check("R6 up-only cycles", up_only, 10);
        check("R6 both cycles",    both_cnt, 1);
        check("R6 no dn-only",     dn_only, 0);
        check("R10 no double both", both_twice, 0);
    endtask

    task automatic test_lead();
        do_reset();
        ratio_hi = 7'd0; ratio_lo = 8'd1; ref_sel = 1'b1;
        clear_counts();
        run_window(0, 500);
        run_window(-1, -1);
        check("R7 dn-only cycles", dn_only, 12);
        check("R7 coincident gives no up-only", up_only, 0);
        check("R7 both cycles", both_cnt, 2);
        check("R10 no double both", both_twice, 0);
    endtask

    task automatic test_lock();
        do_reset();
        ratio_hi = 7'd0; ratio_lo = 8'd1; ref_sel = 1'b1;
        clear_counts();
        for (int k = 0; k < 5; k++) run_window(4, -1);
        run_window(5, -1);
        check("R9 bad width keeps lock low", int'(lock_o), 0);
        for (int k = 0; k < 7; k++) run_window(4, -1);
        check("R8 seven good not locked", int'(lock_o), 0);
        run_window(4, -1);
        check("R8 eight good locked", int'(lock_o), 1);
        run_window(5, -1);
        check("R9 bad width clears lock", int'(lock_o), 0);
        check("R10 no double both", both_twice, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_prog_div();
        test_ref_div();
        test_lag();
        test_lead();
        test_lock();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule